// File: doc/BRIEF.md
# Configuration-Space Sub-Word Access Bridge

This block connects a host-side request stream to a device configuration space. The configuration space is an array of 32-bit words. Each request carries a device/function number, a byte offset, an access size of 1, 2 or 4 bytes, a direction and write data.

The bridge only ever reads and writes whole words. A sub-word read fetches the aligned word and returns the addressed lane, zero-extended. A sub-word write fetches the aligned word, merges the new lane into it and stores the result. After every store the bridge reads the same word back, and only then reports completion. Each request ends with one response pulse that carries a status code and 32 bits of read data.

The bridge also works around an attached device that cannot hold its real first base address. When shadowing is enabled, a full-word write of a real address to the base-address word is kept in a shadow register. The array receives a fixed constant instead. A full-word read of that word returns the shadowed value while the shadow is live. A full-word write of all ones drops the shadow and is stored unchanged, so the size probe still sees the device's own answer.

The request side is valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been delivered, so at most one request is in flight. While `req_ready` is low the host must hold its request. The response side has no back-pressure: `rsp_valid` is high for exactly one cycle and must be taken in that cycle.

Top module: `cfgb_bridge`

## Requirements
- R1: `req_ready` is high exactly when no request is in flight. Every accepted request produces exactly one single-cycle `rsp_valid` pulse. `req_ready` is low from the cycle after acceptance until that pulse. Status codes are 0 = success, 1 = device not found, 2 = bad register number.
- R2: A request with a nonzero device/function number completes with status 1 and read data 0. It leaves the configuration words unchanged. This check wins over the size check.
- R3: A request whose size field is not 1, 2 or 4 completes with status 2 and read data 0. It writes nothing.
- R4: A 1-byte read returns bits [8·k+7 : 8·k] of the word at offset[ADDR_W-1:2], where k = offset[1:0], zero-extended to 32 bits.
- R5: A 2-byte read returns bits [15:0] of the aligned word when offset bit 1 is 0, and bits [31:16] when it is 1, zero-extended. Offset bit 0 is ignored.
- R6: A 1-byte write replaces only byte lane offset[1:0] of the aligned word with wdata[7:0]. It returns status 0 and read data 0.
- R7: A 2-byte write replaces only halfword offset[1] of the aligned word with wdata[15:0].
- R8: A 4-byte write replaces the whole aligned word. A 4-byte read returns it, except in the case covered by R11.
- R9: With shadowing on, a 4-byte write at byte offset BAR_OFFSET (default 0x10) of any value other than 0xFFFFFFFF stores the value in the shadow and makes the shadow live. It stores 0x0000FFFF into the array word. Writes to other offsets are never substituted.
- R10: A 4-byte write of 0xFFFFFFFF at BAR_OFFSET makes the shadow not live and stores 0xFFFFFFFF into the word.
- R11: A 4-byte read at BAR_OFFSET returns the shadow while it is live. Sub-word reads of that word return array contents. A sub-word write to that word leaves the shadow live.
- R12: Every write is followed by a read-back of the same word before its response. Latency from the accepting edge to the response cycle is 1 cycle for a rejected request, 2 for a read and 4 for a write.
- R13: Reset clears every configuration word, the shadow register and the live flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle and able to take a request |
| req_devfn | input | DEVFN_W | Device/function number; only 0 is served |
| req_offset | input | ADDR_W | Byte offset into configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 legal) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | Completion status (0 ok, 1 no device, 2 bad register) |
| rsp_rdata | output | 32 | Read data, zero-extended; 0 for writes and errors |

## Verification
The bench builds the bridge with ADDR_W = 8, which gives 64 words, and keeps shadowing on at the default offset 0x10 with the default substitute constant. The small array puts the last word, at offsets 0xFC to 0xFF, within a few vectors, so lane extraction at the top of the space is exercised. The same build reaches the shadow word, a plain neighbour word at 0x14, and every byte and halfword lane of a working word. Together these cover capture, probe release, mixed sub-word access to the shadowed word, and clearing by a reset in mid-run.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  localparam int CFG_DW = 32;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_NODEV  = 2'd1,
    ST_BADREG = 2'd2
  } cfg_status_e;

  typedef enum logic [1:0] {
    SZ_BYTE,
    SZ_HALF,
    SZ_WORD,
    SZ_BAD
  } acc_size_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_LOAD,
    F_FLUSH,
    F_FLUSH_WAIT,
    F_RESP
  } fsm_e;

  function automatic acc_size_e decode_size(input logic [2:0] sz);
    case (sz)
      3'd1:    return SZ_BYTE;
      3'd2:    return SZ_HALF;
      3'd4:    return SZ_WORD;
      default: return SZ_BAD;
    endcase
  endfunction

endpackage

// File: rtl/cfgb_regfile.sv
module cfgb_regfile #(
  parameter int WADDR_W = 10,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [WADDR_W-1:0] rd_addr,
  output logic [DW-1:0]      rd_data,
  input  logic               wr_en,
  input  logic [WADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]      wr_data
);

  localparam int WORDS = 2 ** WADDR_W;

  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
      if (rd_en) rd_data <= mem_q[rd_addr];
    end
  end

  // The sequencer never fetches and stores in the same cycle (R12 ordering).
  assert_no_rw_collision_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !rd_en);

endmodule

// File: rtl/cfgb_lane_unit.sv
module cfgb_lane_unit
  import cfgb_pkg::*;
(
  input  logic [CFG_DW-1:0] word,
  input  logic [1:0]        lane,
  input  acc_size_e         size,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] extract,
  output logic [CFG_DW-1:0] merged
);

  localparam int LANES = CFG_DW / 8;

  logic [4:0]        shamt;
  logic [CFG_DW-1:0] shifted;

  always_comb begin
    case (size)
      SZ_BYTE: shamt = {lane, 3'b000};
      SZ_HALF: shamt = {lane[1], 4'b0000};
      default: shamt = 5'd0;
    endcase
    shifted = word >> shamt;
    case (size)
      SZ_BYTE: extract = {24'd0, shifted[7:0]};
      SZ_HALF: extract = {16'd0, shifted[15:0]};
      default: extract = shifted;
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic       be;
    logic [7:0] src;
    always_comb begin
      case (size)
        SZ_BYTE: begin
          be  = (lane == 2'(i));
          src = wdata[7:0];
        end
        SZ_HALF: begin
          be  = (lane[1] == 1'(i / 2));
          src = wdata[(i % 2) * 8 +: 8];
        end
        SZ_WORD: begin
          be  = 1'b1;
          src = wdata[i * 8 +: 8];
        end
        default: begin
          be  = 1'b0;
          src = word[i * 8 +: 8];
        end
      endcase
    end
    assign merged[i * 8 +: 8] = be ? src : word[i * 8 +: 8];
  end

endmodule

// File: rtl/cfgb_bar_shadow.sv
module cfgb_bar_shadow #(
  parameter bit          ENABLE      = 1'b1,
  parameter logic [31:0] STORE_CONST = 32'h0000_FFFF,
  parameter logic [31:0] PROBE       = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic [31:0] word_in,
  output logic        cached,
  output logic [31:0] shadow,
  output logic [31:0] word_out
);

  if (ENABLE) begin : g_on
    logic        live_q;
    logic [31:0] val_q;
    logic        is_probe;

    assign is_probe = (word_in == PROBE);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q <= 1'b0;
        val_q  <= '0;
      end else if (cap_en) begin
        live_q <= !is_probe;
        if (!is_probe) val_q <= word_in;
      end
    end

    assign cached   = live_q;
    assign shadow   = val_q;
    assign word_out = (cap_en && !is_probe) ? STORE_CONST : word_in;

    assert_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && word_in != PROBE) |=> (cached && shadow == $past(word_in)));

    assert_probe_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && word_in == PROBE) |=> !cached);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> ($stable(cached) && $stable(shadow)));
  end else begin : g_off
    assign cached   = 1'b0;
    assign shadow   = '0;
    assign word_out = word_in;
  end

endmodule

// File: rtl/cfgb_bridge.sv
module cfgb_bridge
  import cfgb_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          DEVFN_W     = 8,
  parameter bit          SHADOW_EN   = 1'b1,
  parameter int          BAR_OFFSET  = 16,
  parameter logic [31:0] SHADOW_CONST = 32'h0000_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [DEVFN_W-1:0] req_devfn,
  input  logic [ADDR_W-1:0]  req_offset,
  input  logic [2:0]         req_size,
  input  logic               req_write,
  input  logic [31:0]        req_wdata,
  output logic               rsp_valid,
  output logic [1:0]         rsp_status,
  output logic [31:0]        rsp_rdata
);

  localparam int WADDR_W = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] BAR_ADDR = ADDR_W'(BAR_OFFSET);

  fsm_e                state_q;
  logic                t_write_q;
  logic [WADDR_W-1:0]  t_waddr_q;
  logic [1:0]          t_lane_q;
  acc_size_e           t_size_q;
  logic [31:0]         t_wdata_q;
  logic                t_bar_q;
  cfg_status_e         st_q;
  logic [31:0]         rdata_q;

  logic                accept;
  acc_size_e           in_size;
  logic                in_nodev;
  logic                in_bad;

  logic                rd_en;
  logic [WADDR_W-1:0]  rd_addr;
  logic [31:0]         rd_data;
  logic                wr_en;
  logic [31:0]         wr_data;

  logic [31:0]         lane_extract;
  logic [31:0]         lane_merged;
  logic                sh_cap;
  logic                sh_cached;
  logic [31:0]         sh_value;

  assign req_ready = (state_q == F_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_size   = decode_size(req_size);
  assign in_nodev  = (req_devfn != '0);
  assign in_bad    = (in_size == SZ_BAD);

  assign rd_en   = (accept && !in_nodev && !in_bad) || (state_q == F_FLUSH);
  assign rd_addr = (state_q == F_IDLE) ? req_offset[ADDR_W-1:2] : t_waddr_q;
  assign wr_en   = (state_q == F_LOAD) && t_write_q;
  assign sh_cap  = wr_en && t_bar_q;

  cfgb_regfile #(
    .WADDR_W (WADDR_W),
    .DW      (32)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (t_waddr_q),
    .wr_data (wr_data)
  );

  cfgb_lane_unit u_lanes (
    .word    (rd_data),
    .lane    (t_lane_q),
    .size    (t_size_q),
    .wdata   (t_wdata_q),
    .extract (lane_extract),
    .merged  (lane_merged)
  );

  cfgb_bar_shadow #(
    .ENABLE      (SHADOW_EN),
    .STORE_CONST (SHADOW_CONST),
    .PROBE       (32'hFFFF_FFFF)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (sh_cap),
    .word_in  (lane_merged),
    .cached   (sh_cached),
    .shadow   (sh_value),
    .word_out (wr_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= F_IDLE;
      t_write_q <= 1'b0;
      t_waddr_q <= '0;
      t_lane_q  <= '0;
      t_size_q  <= SZ_BYTE;
      t_wdata_q <= '0;
      t_bar_q   <= 1'b0;
      st_q      <= ST_OK;
      rdata_q   <= '0;
    end else begin
      case (state_q)
        F_IDLE: begin
          if (accept) begin
            t_write_q <= req_write;
            t_waddr_q <= req_offset[ADDR_W-1:2];
            t_lane_q  <= req_offset[1:0];
            t_size_q  <= in_size;
            t_wdata_q <= req_wdata;
            t_bar_q   <= (req_offset == BAR_ADDR) && (in_size == SZ_WORD);
            rdata_q   <= '0;
            if (in_nodev) begin
              st_q    <= ST_NODEV;
              state_q <= F_RESP;
            end else if (in_bad) begin
              st_q    <= ST_BADREG;
              state_q <= F_RESP;
            end else begin
              st_q    <= ST_OK;
              state_q <= F_LOAD;
            end
          end
        end
        F_LOAD: begin
          if (t_write_q) begin
            state_q <= F_FLUSH;
          end else begin
            rdata_q <= (t_bar_q && sh_cached) ? sh_value : lane_extract;
            state_q <= F_RESP;
          end
        end
        F_FLUSH:      state_q <= F_FLUSH_WAIT;
        F_FLUSH_WAIT: state_q <= F_RESP;
        F_RESP:       state_q <= F_IDLE;
        default:      state_q <= F_IDLE;
      endcase
    end
  end

  assign rsp_valid  = (state_q == F_RESP);
  assign rsp_status = st_q;
  assign rsp_rdata  = rdata_q;

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  assert_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_nodev_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_devfn != '0) |=> (rsp_valid && rsp_status == 2'd1 && rsp_rdata == '0));

  assert_badsize_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_devfn == '0 && req_size != 3'd1 && req_size != 3'd2 && req_size != 3'd4)
    |=> (rsp_valid && rsp_status == 2'd2));

  assert_readback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_en && rd_addr == $past(t_waddr_q)));

  assert_shadow_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == F_LOAD && !t_write_q && t_bar_q && sh_cached) |=> (rsp_rdata == $past(sh_value)));

endmodule

// File: tb/test_cfgb_bridge.sv
`timescale 1ns/1ps
module test_cfgb_bridge;

  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_devfn = '0;
  logic [AW-1:0] req_offset = '0;
  logic [2:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cfgb_bridge #(
    .ADDR_W     (AW),
    .DEVFN_W    (8),
    .SHADOW_EN  (1'b1),
    .BAR_OFFSET (16)
  ) i_cfgb_bridge (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_devfn  (req_devfn),
    .req_offset (req_offset),
    .req_size   (req_size),
    .req_write  (req_write),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  devfn;
    logic [7:0]  off;
    logic [2:0]  sz;
    logic [31:0] wd;
    logic [1:0]  st;
    logic [31:0] rd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VT [NV] = '{
    '{1'b1, 8'h00, 8'h20, 3'd4, 32'h11223344, 2'd0, 32'h00000000, 4'd8},  // R8
    '{1'b0, 8'h00, 8'h20, 3'd4, 32'h0,        2'd0, 32'h11223344, 4'd8},  // R8
    '{1'b0, 8'h00, 8'h20, 3'd1, 32'h0,        2'd0, 32'h00000044, 4'd4},  // R4
    '{1'b0, 8'h00, 8'h21, 3'd1, 32'h0,        2'd0, 32'h00000033, 4'd4},  // R4
    '{1'b0, 8'h00, 8'h22, 3'd1, 32'h0,        2'd0, 32'h00000022, 4'd4},  // R4
    '{1'b0, 8'h00, 8'h23, 3'd1, 32'h0,        2'd0, 32'h00000011, 4'd4},  // R4
    '{1'b0, 8'h00, 8'h20, 3'd2, 32'h0,        2'd0, 32'h00003344, 4'd5},  // R5
    '{1'b0, 8'h00, 8'h22, 3'd2, 32'h0,        2'd0, 32'h00001122, 4'd5},  // R5
    '{1'b0, 8'h00, 8'h23, 3'd2, 32'h0,        2'd0, 32'h00001122, 4'd5},  // R5 bit0 ignored
    '{1'b0, 8'h00, 8'h21, 3'd2, 32'h0,        2'd0, 32'h00003344, 4'd5},  // R5 bit0 ignored
    '{1'b1, 8'h00, 8'h21, 3'd1, 32'hFFFFFFAB, 2'd0, 32'h0,        4'd6},  // R6
    '{1'b0, 8'h00, 8'h20, 3'd4, 32'h0,        2'd0, 32'h1122AB44, 4'd6},  // R6
    '{1'b1, 8'h00, 8'h22, 3'd2, 32'h0000BEEF, 2'd0, 32'h0,        4'd7},  // R7
    '{1'b1, 8'h00, 8'h21, 3'd2, 32'h00005A5A, 2'd0, 32'h0,        4'd7},  // R7
    '{1'b0, 8'h00, 8'h20, 3'd4, 32'h0,        2'd0, 32'hBEEF5A5A, 4'd7},  // R7
    '{1'b1, 8'h00, 8'h23, 3'd1, 32'h00000077, 2'd0, 32'h0,        4'd6},  // R6
    '{1'b0, 8'h00, 8'h20, 3'd4, 32'h0,        2'd0, 32'h77EF5A5A, 4'd6},  // R6
    '{1'b1, 8'h08, 8'h20, 3'd4, 32'h0,        2'd1, 32'h0,        4'd2},  // R2
    '{1'b0, 8'h01, 8'h20, 3'd4, 32'h0,        2'd1, 32'h0,        4'd2},  // R2
    '{1'b0, 8'h00, 8'h20, 3'd4, 32'h0,        2'd0, 32'h77EF5A5A, 4'd2},  // R2 untouched
    '{1'b1, 8'h00, 8'h20, 3'd3, 32'h0,        2'd2, 32'h0,        4'd3},  // R3
    '{1'b0, 8'h00, 8'h20, 3'd0, 32'h0,        2'd2, 32'h0,        4'd3},  // R3
    '{1'b0, 8'h00, 8'h20, 3'd5, 32'h0,        2'd2, 32'h0,        4'd3},  // R3
    '{1'b1, 8'h00, 8'h20, 3'd7, 32'h0,        2'd2, 32'h0,        4'd3},  // R3
    '{1'b0, 8'h00, 8'h20, 3'd4, 32'h0,        2'd0, 32'h77EF5A5A, 4'd3},  // R3 untouched
    '{1'b1, 8'h02, 8'h20, 3'd3, 32'h0,        2'd1, 32'h0,        4'd2},  // R2 wins over R3
    '{1'b1, 8'h00, 8'h10, 3'd4, 32'hE0001000, 2'd0, 32'h0,        4'd9},  // R9
    '{1'b0, 8'h00, 8'h10, 3'd4, 32'h0,        2'd0, 32'hE0001000, 4'd11}, // R11
    '{1'b0, 8'h00, 8'h10, 3'd2, 32'h0,        2'd0, 32'h0000FFFF, 4'd9},  // R9
    '{1'b0, 8'h00, 8'h12, 3'd2, 32'h0,        2'd0, 32'h00000000, 4'd9},  // R9
    '{1'b0, 8'h00, 8'h11, 3'd1, 32'h0,        2'd0, 32'h000000FF, 4'd11}, // R11
    '{1'b1, 8'h00, 8'h10, 3'd4, 32'hFFFFFFFF, 2'd0, 32'h0,        4'd10}, // R10
    '{1'b0, 8'h00, 8'h10, 3'd4, 32'h0,        2'd0, 32'hFFFFFFFF, 4'd10}, // R10
    '{1'b1, 8'h00, 8'h10, 3'd4, 32'h12345678, 2'd0, 32'h0,        4'd9},  // R9
    '{1'b1, 8'h00, 8'h10, 3'd1, 32'h00000000, 2'd0, 32'h0,        4'd11}, // R11
    '{1'b0, 8'h00, 8'h10, 3'd4, 32'h0,        2'd0, 32'h12345678, 4'd11}, // R11
    '{1'b0, 8'h00, 8'h10, 3'd2, 32'h0,        2'd0, 32'h0000FF00, 4'd11}, // R11
    '{1'b1, 8'h00, 8'h14, 3'd4, 32'hFFFF0000, 2'd0, 32'h0,        4'd9},  // R9 other offset
    '{1'b0, 8'h00, 8'h14, 3'd4, 32'h0,        2'd0, 32'hFFFF0000, 4'd9},  // R9 other offset
    '{1'b1, 8'h00, 8'hFC, 3'd4, 32'hAABBCCDD, 2'd0, 32'h0,        4'd4},  // R4
    '{1'b0, 8'h00, 8'hFF, 3'd1, 32'h0,        2'd0, 32'h000000AA, 4'd4},  // R4
    '{1'b0, 8'h00, 8'hFE, 3'd2, 32'h0,        2'd0, 32'h0000AABB, 4'd5}   // R5
  };

  logic [1:0]  got_st;
  logic [31:0] got_rd;
  int          got_lat;
  logic        got_busy_rdy;

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [7:0] dv, input logic [7:0] off,
                        input logic [2:0] sz, input logic [31:0] wd);
    bit acc;
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_devfn  = dv;
    req_offset = off;
    req_size   = sz;
    req_wdata  = wd;
    acc = 1'b0;
    while (!acc) begin
      acc = req_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    got_busy_rdy = req_ready;
    got_lat = 1;
    while (!rsp_valid && got_lat < 40) begin
      @(negedge clk);
      got_lat++;
    end
    if (!rsp_valid) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1: actual no response expected response");
      got_st = 2'd3;
      got_rd = '0;
    end else begin
      got_st = rsp_status;
      got_rd = rsp_rdata;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R13 reset state
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", {30'd0, req_ready, rsp_valid}, 32'h2);
    do_req(1'b0, 8'h00, 8'h10, 3'd4, 32'h0);
    check(got_st == 2'd0 && got_rd == 32'h0, "R13", got_rd, 32'h0);
    do_req(1'b0, 8'h00, 8'h20, 3'd4, 32'h0);
    check(got_st == 2'd0 && got_rd == 32'h0, "R13", got_rd, 32'h0);
    check(got_lat == 2, "R12", 32'(got_lat), 32'd2);

    for (int i = 0; i < NV; i++) begin
      do_req(VT[i].wr, VT[i].devfn, VT[i].off, VT[i].sz, VT[i].wd);
      n_checks++;
      if (got_st !== VT[i].st || got_rd !== VT[i].rd) begin
        n_fails++;
        $display("FAIL R%0d vec %0d: actual st=%0d rd=%h expected st=%0d rd=%h",
                 VT[i].rq, i, got_st, got_rd, VT[i].st, VT[i].rd);
      end
    end

    // R12 latency and R1 back-pressure
    do_req(1'b1, 8'h00, 8'h30, 3'd2, 32'h00001234);
    check(got_lat == 4, "R12", 32'(got_lat), 32'd4);
    check(got_busy_rdy == 1'b0, "R1", {31'd0, got_busy_rdy}, 32'd0);
    do_req(1'b0, 8'h05, 8'h30, 3'd4, 32'h0);
    check(got_lat == 1, "R12", 32'(got_lat), 32'd1);
    do_req(1'b0, 8'h00, 8'h30, 3'd4, 32'h0);
    check(got_lat == 2 && got_rd == 32'h00001234, "R12", got_rd, 32'h00001234);

    // R13 reset in mid-run clears array, shadow and flag
    do_req(1'b1, 8'h00, 8'h10, 3'd4, 32'hCAFE0000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_req(1'b0, 8'h00, 8'h10, 3'd4, 32'h0);
    check(got_rd == 32'h0, "R13", got_rd, 32'h0);
    do_req(1'b0, 8'h00, 8'h20, 3'd4, 32'h0);
    check(got_rd == 32'h0, "R13", got_rd, 32'h0);

    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule